// File: doc/BRIEF.md
# PFM Frequency Estimator and Linearizer

This block sits behind the digital low-pass stage of a pulse-frequency-modulated converter. It turns the filtered sample stream back into linear amplitude codes. A moving sum over the most recent `NFIR` accepted samples estimates the oscillation frequency. The estimate is then decimated by `DEC`, so only every `DEC`-th full-window sum goes on. Each surviving sum addresses a programmable inverse-characteristic table, and the table entry is the output code. The table holds the inverse of the exponential frequency-versus-input curve of a passive RC integrator. It is computed off-block from a measured time constant and loaded while the calibration input is high.

Because the correction runs after decimation, only one table read is needed per output sample. The sum word is `DATA_W + log2(NFIR)` bits wide. Its top `LUT_AW` bits form the table index.

Top module: `pfm_linearizer`

## Requirements
- R1: After `rst_ni` is released, `out_valid_o` is low, and the accumulator, delay line, fill count and decimation phase all start from zero, so samples accepted before the reset carry no weight afterwards.
- R2: The frequency estimate is the unweighted sum of the last `NFIR` accepted samples (default 16), carried in `DATA_W + log2(NFIR)` bits without overflow, up to full-scale input on every tap.
- R3: No output is produced until `NFIR` samples have been accepted since reset.
- R4: Number the accepted samples k = 1, 2, … from reset. An output is produced for sample k exactly when k ≥ `NFIR` and (k − `NFIR` + 1) is a multiple of `DEC` (default 8). No other output is produced.
- R5: The output code is the table entry at index `sum >> (SUM_W − LUT_AW)`, the upper `LUT_AW` bits of the window sum.
- R6: A table write at `tbl_addr_i` with `tbl_data_i` takes effect only when `tbl_we_i` and `cal_mode_i` are both high on a clock edge. A write strobe while `cal_mode_i` is low leaves the table unchanged.
- R7: `out_valid_o` stays low in every cycle that follows a clock edge at which `cal_mode_i` was high.
- R8: `out_valid_o` rises two clock edges after the edge that accepts the sample producing it: edge n accepts the sample, and the output is valid after edge n+2.
- R9: Cycles with `in_valid_i` low change neither the window contents nor the decimation phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample strobe |
| in_data_i | input | DATA_W | Low-pass filtered sample, unsigned |
| cal_mode_i | input | 1 | Calibration mode; enables table writes and blocks output |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_addr_i | input | LUT_AW | Table write address |
| tbl_data_i | input | OUT_W | Table write data |
| out_valid_o | output | 1 | Corrected output strobe |
| out_data_o | output | OUT_W | Corrected amplitude code |

## Verification
The bench runs random sample values with random idle gaps between them. A window or phase that moved on idle cycles would shift which samples give an output, and the shift would appear as a missing or extra strobe. Directed full-scale runs give a sum of 65520. A design that lost the carry bit would read the wrong table entry. The bench also sends samples during calibration and issues a write strobe with calibration low. These catch a design that leaks outputs during calibration or accepts writes outside it. Every output is matched against the expected clock cycle, so a wrong pipeline depth or decimation phase shows up at once.

// File: rtl/pfm_pkg.sv
package pfm_pkg;
  localparam int unsigned DATA_W_D = 12;
  localparam int unsigned NFIR_D   = 16;
  localparam int unsigned DEC_D    = 8;
  localparam int unsigned LUT_AW_D = 8;
  localparam int unsigned OUT_W_D  = 12;

  function automatic int unsigned sum_width(input int unsigned dw, input int unsigned ntap);
    return dw + $clog2(ntap);
  endfunction
endpackage

// File: rtl/pfm_moving_sum.sv
module pfm_moving_sum #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned NTAP   = 16,
  localparam int unsigned SUM_W = pfm_pkg::sum_width(DATA_W, NTAP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              sum_valid_o,
  output logic [SUM_W-1:0]  sum_o
);
  localparam int unsigned CNT_W = $clog2(NTAP + 1);
  localparam logic [SUM_W-1:0] SUM_MAX = SUM_W'(NTAP * ((2 ** DATA_W) - 1));

  logic [DATA_W-1:0] tap_q [NTAP];
  logic [SUM_W-1:0]  acc_q;
  logic [CNT_W-1:0]  fill_q;
  logic              sum_v_q;

  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tap_q[i] <= '0;
      else if (in_valid_i) begin
        if (i == 0) tap_q[i] <= in_data_i;
        else        tap_q[i] <= tap_q[(i == 0) ? 0 : i-1];
      end
    end
  end

  // running sum: add newest, drop the sample leaving the window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      fill_q  <= '0;
      sum_v_q <= 1'b0;
    end else begin
      sum_v_q <= in_valid_i && (fill_q >= CNT_W'(NTAP - 1));
      if (in_valid_i) begin
        acc_q <= acc_q + SUM_W'(in_data_i) - SUM_W'(tap_q[NTAP-1]);
        if (fill_q != CNT_W'(NTAP)) fill_q <= fill_q + 1'b1;
      end
    end
  end

  assign sum_valid_o = sum_v_q;
  assign sum_o       = acc_q;

  AST_SUM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q <= SUM_MAX); // R2
  AST_SUM_FROM_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_v_q |-> $past(in_valid_i)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(acc_q)); // R9
endmodule

// File: rtl/pfm_decimator.sv
module pfm_decimator #(
  parameter int unsigned SUM_W = 16,
  parameter int unsigned DEC   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sum_valid_i,
  input  logic [SUM_W-1:0] sum_i,
  output logic             dec_valid_o,
  output logic [SUM_W-1:0] dec_sum_o
);
  localparam int unsigned PH_W = (DEC > 1) ? $clog2(DEC) : 1;

  logic [PH_W-1:0]  phase_q;
  logic             dec_v_q;
  logic [SUM_W-1:0] dec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      dec_v_q <= 1'b0;
      dec_q   <= '0;
    end else begin
      dec_v_q <= 1'b0;
      if (sum_valid_i) begin
        if (phase_q == PH_W'(DEC - 1)) begin
          phase_q <= '0;
          dec_v_q <= 1'b1;
          dec_q   <= sum_i;
        end else begin
          phase_q <= phase_q + 1'b1;
        end
      end
    end
  end

  assign dec_valid_o = dec_v_q;
  assign dec_sum_o   = dec_q;

  AST_DEC_FROM_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_v_q |-> $past(sum_valid_i)); // R4
  AST_DEC_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (DEC > 1 && dec_v_q) |=> !dec_v_q); // R4
endmodule

// File: rtl/pfm_inv_lut.sv
module pfm_inv_lut #(
  parameter int unsigned SUM_W  = 16,
  parameter int unsigned LUT_AW = 8,
  parameter int unsigned OUT_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cal_mode_i,
  input  logic              tbl_we_i,
  input  logic [LUT_AW-1:0] tbl_addr_i,
  input  logic [OUT_W-1:0]  tbl_data_i,
  input  logic              dec_valid_i,
  input  logic [SUM_W-1:0]  dec_sum_i,
  output logic              out_valid_o,
  output logic [OUT_W-1:0]  out_data_o
);
  localparam int unsigned DEPTH = 2 ** LUT_AW;

  logic [OUT_W-1:0]  mem_q [DEPTH];
  logic [LUT_AW-1:0] rd_idx;
  logic              out_v_q;
  logic [OUT_W-1:0]  out_d_q;

  assign rd_idx = LUT_AW'(dec_sum_i >> (SUM_W - LUT_AW));

  always_ff @(posedge clk_i) begin
    if (cal_mode_i && tbl_we_i) mem_q[tbl_addr_i] <= tbl_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_v_q <= 1'b0;
      out_d_q <= '0;
    end else begin
      out_v_q <= dec_valid_i && !cal_mode_i;
      if (dec_valid_i) out_d_q <= mem_q[rd_idx];
    end
  end

  assign out_valid_o = out_v_q;
  assign out_data_o  = out_d_q;

  AST_CAL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_mode_i |=> !out_v_q); // R7
  AST_ONE_CYCLE_LOOKUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_v_q |-> $past(dec_valid_i)); // R8
endmodule

// File: rtl/pfm_linearizer.sv
module pfm_linearizer #(
  parameter int unsigned DATA_W = pfm_pkg::DATA_W_D,
  parameter int unsigned NFIR   = pfm_pkg::NFIR_D,
  parameter int unsigned DEC    = pfm_pkg::DEC_D,
  parameter int unsigned LUT_AW = pfm_pkg::LUT_AW_D,
  parameter int unsigned OUT_W  = pfm_pkg::OUT_W_D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              cal_mode_i,
  input  logic              tbl_we_i,
  input  logic [LUT_AW-1:0] tbl_addr_i,
  input  logic [OUT_W-1:0]  tbl_data_i,
  output logic              out_valid_o,
  output logic [OUT_W-1:0]  out_data_o
);
  localparam int unsigned SUM_W = pfm_pkg::sum_width(DATA_W, NFIR);

  logic             sum_v;
  logic [SUM_W-1:0] sum;
  logic             dec_v;
  logic [SUM_W-1:0] dec_sum;

  pfm_moving_sum #(.DATA_W(DATA_W), .NTAP(NFIR)) u_sum (
    .clk_i, .rst_ni, .in_valid_i, .in_data_i,
    .sum_valid_o(sum_v), .sum_o(sum)
  );

  pfm_decimator #(.SUM_W(SUM_W), .DEC(DEC)) u_dec (
    .clk_i, .rst_ni, .sum_valid_i(sum_v), .sum_i(sum),
    .dec_valid_o(dec_v), .dec_sum_o(dec_sum)
  );

  pfm_inv_lut #(.SUM_W(SUM_W), .LUT_AW(LUT_AW), .OUT_W(OUT_W)) u_lut (
    .clk_i, .rst_ni, .cal_mode_i, .tbl_we_i, .tbl_addr_i, .tbl_data_i,
    .dec_valid_i(dec_v), .dec_sum_i(dec_sum),
    .out_valid_o, .out_data_o
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !out_valid_o); // R1
endmodule

// File: tb/pfm_linearizer_test.sv
module pfm_linearizer_test;
  localparam int DATA_W = 12, NFIR = 16, DEC = 8, LUT_AW = 8, OUT_W = 12;
  localparam int SUM_W = DATA_W + $clog2(NFIR);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic in_valid_i = 1'b0, cal_mode_i = 1'b0, tbl_we_i = 1'b0;
  logic [DATA_W-1:0] in_data_i = '0;
  logic [LUT_AW-1:0] tbl_addr_i = '0;
  logic [OUT_W-1:0]  tbl_data_i = '0;
  logic out_valid_o;
  logic [OUT_W-1:0] out_data_o;

  pfm_linearizer uut (
    .clk_i(clk), .rst_ni, .in_valid_i, .in_data_i, .cal_mode_i,
    .tbl_we_i, .tbl_addr_i, .tbl_data_i, .out_valid_o, .out_data_o
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, n_out = 0, n_exp = 0;
  int hist [NFIR];
  int lut_m [2**LUT_AW];
  int count = 0;
  int exp_d [$];
  int exp_c [$];
  int exp_r [$];
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int lut_fn(int a, int k);
    return ((a * a) >> 4) ^ (a * k) & 12'hfff;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // monitor: every strobe must match the expected cycle and code
  always @(negedge clk) if (rst_ni && !done) begin
    if (exp_c.size() > 0 && exp_c[0] == cyc) begin
      check(out_valid_o, (exp_r[0] == 2) ? "R2" : "R4/R8", out_valid_o, 1);
      if (out_valid_o) begin
        check(out_data_o == OUT_W'(exp_d[0]), "R5", out_data_o, exp_d[0]);
        n_out++;
      end
      void'(exp_c.pop_front()); void'(exp_d.pop_front()); void'(exp_r.pop_front());
    end else if (out_valid_o) begin
      check(0, cal_mode_i ? "R7" : "R3/R4", 1, 0);
    end
  end

  task automatic put(int v);
    int s = 0;
    in_valid_i = 1'b1; in_data_i = DATA_W'(v);
    for (int i = NFIR-1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = v;
    count++;
    if (count >= NFIR && ((count - NFIR + 1) % DEC) == 0 && !cal_mode_i) begin
      for (int i = 0; i < NFIR; i++) s += hist[i];
      exp_d.push_back(lut_m[s >> (SUM_W - LUT_AW)]);
      exp_c.push_back(cyc + 3);
      exp_r.push_back((v == 4095) ? 2 : 5);
      n_exp++;
    end
    @(negedge clk);
    in_valid_i = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load_table(int k);
    cal_mode_i = 1'b1;
    for (int a = 0; a < 2**LUT_AW; a++) begin
      tbl_we_i = 1'b1; tbl_addr_i = LUT_AW'(a);
      lut_m[a] = lut_fn(a, k); tbl_data_i = OUT_W'(lut_m[a]);
      @(negedge clk);
    end
    tbl_we_i = 1'b0;
  endtask

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    for (int i = 0; i < NFIR; i++) hist[i] = 0;
    idle(3);
    check(out_valid_o == 1'b0, "R1", out_valid_o, 0);
    rst_ni = 1'b1;
    idle(2);
    check(out_valid_o == 1'b0, "R1", out_valid_o, 0);

    // R6/R7: load table; samples during calibration yield nothing
    load_table(3);
    for (int i = 0; i < 30; i++) put($urandom_range(0, 4095));
    idle(4);
    cal_mode_i = 1'b0;
    idle(4);

    // R4/R5: constant stream, index 0x7a
    for (int i = 0; i < 40; i++) put(12'h7a0);
    idle(4);

    // R6: write strobe with calibration low must be ignored
    tbl_we_i = 1'b1; tbl_addr_i = 8'h7a; tbl_data_i = 12'hbad;
    @(negedge clk); tbl_we_i = 1'b0;
    for (int i = 0; i < 24; i++) put(12'h7a0);
    idle(4);

    // R9: random samples with random idle gaps
    for (int i = 0; i < 600; i++) begin
      put($urandom_range(0, 4095));
      idle($urandom_range(0, 2));
    end
    idle(4);

    // recalibrate with a different table
    load_table(5);
    idle(4);
    cal_mode_i = 1'b0;
    idle(4);
    for (int i = 0; i < 300; i++) begin
      put($urandom_range(0, 4095));
      idle($urandom_range(0, 1));
    end

    // R2: full scale on every tap, sum 65520, index 255
    for (int i = 0; i < 40; i++) put(4095);
    idle(8);

    // R1: reset mid-stream, then R3 window refill
    rst_ni = 1'b0; idle(2);
    check(out_valid_o == 1'b0, "R1", out_valid_o, 0);
    rst_ni = 1'b1; count = 0;
    for (int i = 0; i < NFIR; i++) hist[i] = 0;
    exp_c.delete(); exp_d.delete(); exp_r.delete();
    for (int i = 0; i < NFIR + DEC + 3; i++) put($urandom_range(0, 4095));
    idle(8);

    check(exp_c.size() == 0, "R4", exp_c.size(), 0);
    check(n_exp > 100, "R4", n_exp, 101);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule